// File: doc/BRIEF.md
# Bus Ready and Timeout Controller

This block produces the active-high ready signal that closes every processor bus cycle. A cycle is announced by a one-clock address strobe. On that strobe the block captures the address, the memory/I-O and read/write qualifiers, and the two extended address bits. The cycle then runs while the active-low data strobe is held low. The block counts clocks from the fall of the data strobe. It raises ready once the programmed wait count for the selected region has passed. Two external ready inputs of opposite polarity can each hold ready low. Cycles to the block's own I/O window, and all cycles during self-test, skip the wait count.

A single terminal-count output reports two faults. The first is a bus timeout, where a data strobe stays low without ready for a programmed number of clocks. The second is expiry of a watchdog that software reloads by writing to a dedicated I/O address. A free-running divider makes a 100 kHz square-wave timer tick from the CPU clock. The divider uses a programmed clock frequency, in MHz, to set its period.

Top module: `bus_ready_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, rdy, term_cnt and timer_clk are 0, and every counter is cleared.
- R2: cfg_wait holds four 3-bit wait fields; field i sits at bits [3i+2:3i]. Count the clock cycles of a data-strobe-low period from 0. Internal ready is high in cycle k exactly when k is at least the selected field, and stays high until the strobe rises.
- R3: When cfg_ext_en is 1, the field index is the ext_addr value captured at the address strobe; later changes of ext_addr have no effect. When cfg_ext_en is 0, memory cycles (mem_io=1) use field 0 and I/O cycles (mem_io=0) use field 1.
- R4: While ext_rdy is 0, rdy is 0.
- R5: While ext_rdy1_n is 1, rdy is 0.
- R6: In an I/O cycle whose address bits [15:4] equal 0xC0A, and in any cycle while self_test is 1, internal ready is high from the first strobe-low cycle, whatever the wait field.
- R7: rdy is 0 whenever data_strobe_n is 1.
- R8: With cfg_to_limit = L > 0, term_cnt goes high in any strobe-low cycle that is preceded, within the same strobe, by at least L cycles with rdy low. This timeout indication drops as soon as the strobe rises. L = 0 disables the timeout.
- R9: With cfg_wd_en = 1 and reload value W, the watchdog expires if no reload happens. term_cnt then goes high W+2 cycles after the reload cycle and stays high until the next reload, or until cfg_wd_en falls. With cfg_wd_en = 0 the watchdog never expires.
- R10: A reload happens in the first strobe-low cycle of an I/O write (mem_io=0, rd_wr=0) to address 0xC0A3. A read from that address, or a write elsewhere, does not reload.
- R11: With cfg_freq = F > 0, timer_clk toggles every 5*F clocks, which gives 100 kHz when the clock runs at F MHz. With F = 0 it is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_strobe | input | 1 | Active-high address phase strobe; captures cycle information |
| data_strobe_n | input | 1 | Active-low data phase strobe |
| mem_io | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr | input | 16 | Cycle address, captured on addr_strobe |
| ext_addr | input | 2 | Extended address bits from the memory manager |
| ext_rdy | input | 1 | External ready, active high; 0 holds rdy low |
| ext_rdy1_n | input | 1 | Second external ready, active low; 1 holds rdy low |
| self_test | input | 1 | Self-test in progress; forces automatic ready |
| cfg_ext_en | input | 1 | Select wait field by extended address |
| cfg_wait | input | 12 | Four 3-bit wait fields |
| cfg_to_limit | input | 8 | Bus timeout limit in clocks, 0 = off |
| cfg_wd_en | input | 1 | Watchdog enable |
| cfg_wd_reload | input | 32 | Watchdog reload value in clocks |
| cfg_freq | input | 6 | CPU clock frequency in MHz for the tick divider |
| rdy | output | 1 | Bus cycle ready to the processor |
| term_cnt | output | 1 | Bus timeout or watchdog expiry |
| timer_clk | output | 1 | 100 kHz timer tick |

## Verification
The bench uses the default widths: 3-bit wait fields, an 8-bit timeout limit, a 32-bit watchdog and a 6-bit frequency setting. It programs small run-time values. A timeout limit of 6 lets a stalled strobe reach terminal count within one short cycle. A watchdog reload of 40 lets expiry, hold and reload all happen within a few hundred clocks. Frequency settings of 2 and 3 give tick half-periods of 10 and 15 clocks, so many toggles are compared. Every wait field is set to a different value, so a wrong region choice shows up at once as a ready edge in the wrong cycle.

// File: rtl/brc_pkg.sv
package brc_pkg;
    localparam int ADDR_W = 16;
    localparam int EXT_W  = 2;

    typedef struct packed {
        logic              is_mem;
        logic              is_rd;
        logic [EXT_W-1:0]  ext;
        logic [ADDR_W-1:0] addr;
    } bus_cyc_t;
endpackage

// File: rtl/brc_ready_gen.sv
module brc_ready_gen
    import brc_pkg::*;
#(
    parameter int                WAIT_W   = 3,
    parameter logic [ADDR_W-1:0] INT_BASE = 16'hC0A0,
    parameter int                INT_LSB  = 4,
    parameter logic [ADDR_W-1:0] WD_ADDR  = 16'hC0A3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       addr_strobe,
    input  logic                       data_strobe_n,
    input  logic                       mem_io,
    input  logic                       rd_wr,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [EXT_W-1:0]           ext_addr,
    input  logic                       ext_rdy,
    input  logic                       ext_rdy1_n,
    input  logic                       self_test,
    input  logic                       cfg_ext_en,
    input  logic [(1<<EXT_W)*WAIT_W-1:0] cfg_wait,
    output logic                       rdy,
    output logic                       active,
    output logic                       wd_kick
);
    localparam int REGIONS = 1 << EXT_W;
    localparam logic [WAIT_W-1:0] WAIT_MAX = '1;

    typedef struct packed {
        bus_cyc_t          cyc;
        logic [WAIT_W-1:0] wcnt;
        logic              act;
    } rg_state_t;

    rg_state_t st_q, st_d;

    logic [WAIT_W-1:0] field [REGIONS];
    logic [EXT_W-1:0]  sel;
    logic              is_internal;
    logic              int_rdy;

    for (genvar g = 0; g < REGIONS; g++) begin : g_field
        assign field[g] = cfg_wait[g*WAIT_W +: WAIT_W];
    end

    always_comb begin
        active = ~data_strobe_n;

        // region choice: extended bits, or memory/I-O split
        if (cfg_ext_en) begin
            sel = st_q.cyc.ext;
        end else begin
            sel = {{(EXT_W-1){1'b0}}, ~st_q.cyc.is_mem};
        end

        is_internal = ~st_q.cyc.is_mem &&
                      (st_q.cyc.addr[ADDR_W-1:INT_LSB] == INT_BASE[ADDR_W-1:INT_LSB]);

        int_rdy = active && (self_test || is_internal || (st_q.wcnt >= field[sel]));
        rdy     = int_rdy && ext_rdy && ~ext_rdy1_n;

        wd_kick = active && ~st_q.act && ~st_q.cyc.is_mem && ~st_q.cyc.is_rd &&
                  (st_q.cyc.addr == WD_ADDR);

        st_d = st_q;
        if (addr_strobe) begin
            st_d.cyc.is_mem = mem_io;
            st_d.cyc.is_rd  = rd_wr;
            st_d.cyc.ext    = ext_addr;
            st_d.cyc.addr   = addr;
        end
        if (!active) begin
            st_d.wcnt = '0;
        end else if (st_q.wcnt != WAIT_MAX) begin
            st_d.wcnt = st_q.wcnt + 1'b1;
        end
        st_d.act = active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/brc_bus_timeout.sv
module brc_bus_timeout #(
    parameter int TO_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active,
    input  logic            rdy,
    input  logic [TO_W-1:0] cfg_to_limit,
    output logic            to_hit
);
    logic [TO_W-1:0] cnt_q, cnt_d;

    always_comb begin
        to_hit = active && (cfg_to_limit != '0) && (cnt_q >= cfg_to_limit);

        cnt_d = cnt_q;
        if (!active) begin
            cnt_d = '0;
        end else if (!rdy && (cnt_q < cfg_to_limit)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/brc_watchdog.sv
module brc_watchdog #(
    parameter int WD_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wd_en,
    input  logic [WD_W-1:0] cfg_wd_reload,
    input  logic            wd_kick,
    output logic            wd_expired
);
    typedef struct packed {
        logic [WD_W-1:0] cnt;
        logic            exp;
    } wd_state_t;

    wd_state_t st_q, st_d;

    always_comb begin
        wd_expired = st_q.exp;
        st_d = st_q;
        if (!cfg_wd_en || wd_kick) begin
            st_d.cnt = cfg_wd_reload;
            st_d.exp = 1'b0;
        end else if (st_q.cnt == '0) begin
            st_d.exp = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/brc_tick_gen.sv
module brc_tick_gen #(
    parameter int FREQ_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FREQ_W-1:0] cfg_freq,
    output logic              timer_clk
);
    localparam int HALF_W = FREQ_W + 3;

    typedef struct packed {
        logic [HALF_W-1:0] div;
        logic              tclk;
    } tk_state_t;

    tk_state_t         st_q, st_d;
    logic [HALF_W-1:0] half;

    always_comb begin
        half      = HALF_W'(cfg_freq) * HALF_W'(5);
        timer_clk = st_q.tclk;
        st_d      = st_q;
        if (half == '0) begin
            st_d.div  = '0;
            st_d.tclk = 1'b0;
        end else if (st_q.div >= half - 1'b1) begin
            st_d.div  = '0;
            st_d.tclk = ~st_q.tclk;
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/bus_ready_ctrl.sv
module bus_ready_ctrl
    import brc_pkg::*;
#(
    parameter int                WAIT_W   = 3,
    parameter int                TO_W     = 8,
    parameter int                WD_W     = 32,
    parameter int                FREQ_W   = 6,
    parameter logic [ADDR_W-1:0] INT_BASE = 16'hC0A0,
    parameter int                INT_LSB  = 4,
    parameter logic [ADDR_W-1:0] WD_ADDR  = 16'hC0A3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           addr_strobe,
    input  logic                           data_strobe_n,
    input  logic                           mem_io,
    input  logic                           rd_wr,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [EXT_W-1:0]               ext_addr,
    input  logic                           ext_rdy,
    input  logic                           ext_rdy1_n,
    input  logic                           self_test,
    input  logic                           cfg_ext_en,
    input  logic [(1<<EXT_W)*WAIT_W-1:0]   cfg_wait,
    input  logic [TO_W-1:0]                cfg_to_limit,
    input  logic                           cfg_wd_en,
    input  logic [WD_W-1:0]                cfg_wd_reload,
    input  logic [FREQ_W-1:0]              cfg_freq,
    output logic                           rdy,
    output logic                           term_cnt,
    output logic                           timer_clk
);
    logic active;
    logic wd_kick;
    logic to_hit;
    logic wd_expired;

    brc_ready_gen #(
        .WAIT_W   (WAIT_W),
        .INT_BASE (INT_BASE),
        .INT_LSB  (INT_LSB),
        .WD_ADDR  (WD_ADDR)
    ) u_ready (
        .clk           (clk),
        .rst_n         (rst_n),
        .addr_strobe   (addr_strobe),
        .data_strobe_n (data_strobe_n),
        .mem_io        (mem_io),
        .rd_wr         (rd_wr),
        .addr          (addr),
        .ext_addr      (ext_addr),
        .ext_rdy       (ext_rdy),
        .ext_rdy1_n    (ext_rdy1_n),
        .self_test     (self_test),
        .cfg_ext_en    (cfg_ext_en),
        .cfg_wait      (cfg_wait),
        .rdy           (rdy),
        .active        (active),
        .wd_kick       (wd_kick)
    );

    brc_bus_timeout #(
        .TO_W (TO_W)
    ) u_timeout (
        .clk          (clk),
        .rst_n        (rst_n),
        .active       (active),
        .rdy          (rdy),
        .cfg_to_limit (cfg_to_limit),
        .to_hit       (to_hit)
    );

    brc_watchdog #(
        .WD_W (WD_W)
    ) u_wdog (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_wd_en     (cfg_wd_en),
        .cfg_wd_reload (cfg_wd_reload),
        .wd_kick       (wd_kick),
        .wd_expired    (wd_expired)
    );

    brc_tick_gen #(
        .FREQ_W (FREQ_W)
    ) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_freq  (cfg_freq),
        .timer_clk (timer_clk)
    );

    assign term_cnt = to_hit | wd_expired;
endmodule

// File: rtl/brc_checker.sv
module brc_checker #(
    parameter int FREQ_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              data_strobe_n,
    input logic              ext_rdy,
    input logic              ext_rdy1_n,
    input logic              self_test,
    input logic              rdy,
    input logic              cfg_wd_en,
    input logic              wd_kick,
    input logic              wd_expired,
    input logic              to_hit,
    input logic [FREQ_W-1:0] cfg_freq,
    input logic              timer_clk
);
    // R7
    idle_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_strobe_n |-> !rdy);

    // R4
    ext_hi_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_rdy |-> !rdy);

    // R5
    ext_lo_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rdy1_n |-> !rdy);

    // R6
    selftest_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_strobe_n && self_test && ext_rdy && !ext_rdy1_n) |-> rdy);

    // R8
    timeout_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_strobe_n |-> !to_hit);

    // R9
    wd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_expired && cfg_wd_en && !wd_kick) |=> wd_expired);

    // R10
    wd_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_kick |=> !wd_expired);

    // R11
    tick_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_freq == '0) |=> !timer_clk);
endmodule

bind bus_ready_ctrl brc_checker #(.FREQ_W(FREQ_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .data_strobe_n (data_strobe_n),
    .ext_rdy       (ext_rdy),
    .ext_rdy1_n    (ext_rdy1_n),
    .self_test     (self_test),
    .rdy           (rdy),
    .cfg_wd_en     (cfg_wd_en),
    .wd_kick       (wd_kick),
    .wd_expired    (wd_expired),
    .to_hit        (to_hit),
    .cfg_freq      (cfg_freq),
    .timer_clk     (timer_clk)
);

// File: tb/bus_ready_ctrl_test.sv
module bus_ready_ctrl_test;
    localparam logic [15:0] BASE = 16'hC0A0;
    localparam logic [15:0] WDA  = 16'hC0A3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_strobe = 1'b0;
    logic        data_strobe_n = 1'b1;
    logic        mem_io = 1'b1;
    logic        rd_wr = 1'b1;
    logic [15:0] addr = '0;
    logic [1:0]  ext_addr = '0;
    logic        ext_rdy = 1'b1;
    logic        ext_rdy1_n = 1'b0;
    logic        self_test = 1'b0;
    logic        cfg_ext_en = 1'b0;
    logic [11:0] cfg_wait = {3'd1, 3'd5, 3'd2, 3'd3};
    logic [7:0]  cfg_to_limit = 8'd0;
    logic        cfg_wd_en = 1'b0;
    logic [31:0] cfg_wd_reload = 32'd40;
    logic [5:0]  cfg_freq = 6'd2;
    logic        rdy, term_cnt, timer_clk;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    always #5 clk = ~clk;

    bus_ready_ctrl uut (
        .clk(clk), .rst_n(rst_n), .addr_strobe(addr_strobe),
        .data_strobe_n(data_strobe_n), .mem_io(mem_io), .rd_wr(rd_wr),
        .addr(addr), .ext_addr(ext_addr), .ext_rdy(ext_rdy),
        .ext_rdy1_n(ext_rdy1_n), .self_test(self_test), .cfg_ext_en(cfg_ext_en),
        .cfg_wait(cfg_wait), .cfg_to_limit(cfg_to_limit), .cfg_wd_en(cfg_wd_en),
        .cfg_wd_reload(cfg_wd_reload), .cfg_freq(cfg_freq),
        .rdy(rdy), .term_cnt(term_cnt), .timer_clk(timer_clk)
    );

    // behavioural reference state
    bit     m_mem, m_rd, m_act, m_exp, m_tclk;
    int     m_ext, m_wcnt, m_to, m_div;
    int     m_addr;
    longint m_wd;

    task automatic check_bit(input string req, input string what, input logic act_v, input bit exp_v);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act_v, exp_v);
        end
    endtask

    always begin
        bit act, e_rdy, e_to, kick;
        int fld, wv, half;
        @(negedge clk);
        #3;
        act   = !data_strobe_n;
        fld   = cfg_ext_en ? m_ext : (m_mem ? 0 : 1);
        wv    = (cfg_wait >> (fld * 3)) & 7;
        e_rdy = act && (self_test || (!m_mem && (m_addr >> 4) == (BASE >> 4)) || m_wcnt >= wv)
                && ext_rdy && !ext_rdy1_n;
        e_to  = act && cfg_to_limit != 0 && m_to >= cfg_to_limit;
        if (rst_n && !done) begin
            check_bit(cur_req, "rdy", rdy, e_rdy);
            check_bit(cur_req, "term_cnt", term_cnt, e_to || m_exp);
            check_bit(cur_req, "timer_clk", timer_clk, m_tclk);
        end
        @(posedge clk);
        if (!rst_n) begin
            m_mem = 0; m_rd = 0; m_act = 0; m_exp = 0; m_tclk = 0;
            m_ext = 0; m_wcnt = 0; m_to = 0; m_div = 0; m_addr = 0; m_wd = 0;
        end else begin
            kick = act && !m_act && !m_mem && !m_rd && m_addr == WDA;
            if (addr_strobe) begin
                m_mem = mem_io; m_rd = rd_wr; m_ext = ext_addr; m_addr = addr;
            end
            m_wcnt = !act ? 0 : (m_wcnt < 7 ? m_wcnt + 1 : 7);
            if (!act) m_to = 0;
            else if (!e_rdy && m_to < cfg_to_limit) m_to = m_to + 1;
            if (!cfg_wd_en || kick) begin m_wd = cfg_wd_reload; m_exp = 0; end
            else if (m_wd == 0) m_exp = 1;
            else m_wd = m_wd - 1;
            half = cfg_freq * 5;
            if (half == 0) begin m_div = 0; m_tclk = 0; end
            else if (m_div >= half - 1) begin m_div = 0; m_tclk = !m_tclk; end
            else m_div = m_div + 1;
            m_act = act;
        end
    end

    task automatic bus_cyc(input bit mem, input bit rd, input logic [15:0] a,
                           input logic [1:0] e, input int n_low);
        @(negedge clk);
        addr_strobe = 1; mem_io = mem; rd_wr = rd; addr = a; ext_addr = e;
        @(negedge clk);
        addr_strobe = 0; data_strobe_n = 0; ext_addr = ~e; addr = 16'h0000;
        repeat (n_low - 1) @(negedge clk);
        @(negedge clk);
        data_strobe_n = 1;
    endtask

    task automatic finish_up;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        finish_up();
    end

    initial begin
        // R1: outputs during reset
        repeat (3) @(negedge clk);
        #3;
        check_bit("R1", "rdy in reset", rdy, 0);
        check_bit("R1", "term_cnt in reset", term_cnt, 0);
        check_bit("R1", "timer_clk in reset", timer_clk, 0);
        @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);

        // R2 R7: wait fields without extended addressing
        cur_req = "R2";
        bus_cyc(1, 1, 16'h0100, 2'd0, 6);
        bus_cyc(0, 0, 16'h0040, 2'd0, 5);
        cur_req = "R7";
        repeat (4) @(negedge clk);

        // R3: field by latched extended bits
        cur_req = "R3";
        cfg_ext_en = 1;
        for (int r = 0; r < 4; r++) bus_cyc(1, 1, 16'h2000, 2'(r), 8);
        bus_cyc(0, 1, 16'h0300, 2'd2, 7);
        cfg_ext_en = 0;

        // R4: active-high external ready held low
        cur_req = "R4";
        ext_rdy = 0;
        bus_cyc(1, 1, 16'h0010, 2'd0, 6);
        ext_rdy = 1;
        // R5: active-low external ready held high
        cur_req = "R5";
        ext_rdy1_n = 1;
        bus_cyc(1, 0, 16'h0010, 2'd0, 6);
        ext_rdy1_n = 0;

        // R6: internal window and self-test bypass
        cur_req = "R6";
        cfg_wait = {3'd7, 3'd7, 3'd7, 3'd7};
        bus_cyc(0, 1, 16'hC0A5, 2'd0, 3);
        bus_cyc(0, 1, 16'hC0B5, 2'd0, 9);
        self_test = 1;
        bus_cyc(1, 1, 16'h4444, 2'd0, 3);
        self_test = 0;
        cfg_wait = {3'd1, 3'd5, 3'd2, 3'd3};

        // R8: bus timeout
        cur_req = "R8";
        cfg_to_limit = 8'd6;
        ext_rdy = 0;
        bus_cyc(1, 1, 16'h0500, 2'd0, 10);
        bus_cyc(1, 1, 16'h0500, 2'd0, 4);
        cfg_to_limit = 8'd0;
        bus_cyc(1, 1, 16'h0500, 2'd0, 10);
        ext_rdy = 1;

        // R9 R10: watchdog
        cur_req = "R10";
        cfg_wd_en = 1;
        for (int k = 0; k < 5; k++) begin
            bus_cyc(0, 0, WDA, 2'd0, 2);
            repeat (20) @(negedge clk);
        end
        cur_req = "R9";
        repeat (60) @(negedge clk);
        #3;
        check_bit("R9", "term_cnt after expiry", term_cnt, 1);
        cur_req = "R10";
        bus_cyc(0, 1, WDA, 2'd0, 2);
        bus_cyc(0, 0, 16'hC0A4, 2'd0, 2);
        #3;
        check_bit("R10", "term_cnt after non-reload cycles", term_cnt, 1);
        bus_cyc(0, 0, WDA, 2'd0, 2);
        #3;
        check_bit("R10", "term_cnt after reload", term_cnt, 0);
        cur_req = "R9";
        repeat (50) @(negedge clk);
        cfg_wd_en = 0;
        repeat (5) @(negedge clk);

        // R11: tick divider
        cur_req = "R11";
        cfg_freq = 6'd3;
        repeat (80) @(negedge clk);
        cfg_freq = 6'd0;
        repeat (20) @(negedge clk);
        #3;
        check_bit("R11", "timer_clk at zero frequency", timer_clk, 0);
        cfg_freq = 6'd2;
        repeat (30) @(negedge clk);

        finish_up();
    end
endmodule